// File: doc/BRIEF.md
# Two-Level Short-Descriptor Address Translator

This block turns a 32-bit virtual address into a 40-bit output address. It walks a two-level translation table held in memory. The requester presents one address at a time. The block then picks one of two table bases, reads one or two 32-bit descriptors through a read port with request and response handshakes, and decodes the last descriptor it reads. Four mapping sizes are supported: 16 MiB supersections, 1 MiB sections, 64 KiB large pages and 4 KiB small pages.

A split control value `cfg_n` (0 to 7) divides the address space between the two bases. Each base has its own disable bit. The answer comes back as a one-cycle pulse that carries:
- an outcome code,
- the translated address,
- a write-allowed flag and an execute-allowed flag.

The outcome code keeps three cases apart: a completed mapping, a translation fault, and a failed memory read. The walk runs through six named states:
- `S_IDLE` waits for a request.
- `S_L1_REQ` and `S_L1_WAIT` issue the first-level read and wait for its data.
- `S_L2_REQ` and `S_L2_WAIT` do the same for the second level.
- `S_RESP` presents the result.

The transitions are:
- accept: `S_IDLE`→`S_L1_REQ`
- disabled: `S_IDLE`→`S_RESP`
- read taken: `S_L1_REQ`→`S_L1_WAIT`, and `S_L2_REQ`→`S_L2_WAIT`
- descend: `S_L1_WAIT`→`S_L2_REQ`
- finish: `S_L1_WAIT`→`S_RESP`, and `S_L2_WAIT`→`S_RESP`
- return: `S_RESP`→`S_IDLE`

Top module: `sdw_walker`

## Requirements
- R1: Base 0 is selected when `cfg_n` is 0, or when virtual-address bits 31 down to 32-`cfg_n` are all zero. Otherwise base 1 is selected, and the walk then proceeds as if `cfg_n` were 0.
- R2: If the disable bit of the selected base (`cfg_dis0` for base 0, `cfg_dis1` for base 1) is set, the walk ends with status 1 (fault) and no memory read is issued.
- R3: The first read address is base[31:14-n], then va[31-n:20], then two zero bits, where n is the effective split value.
- R4: First-level descriptor bits[1:0] decode as follows: 00 gives a fault, 01 continues to a second read, and 10 or 11 maps directly. At most two reads happen per walk.
- R5: A direct mapping with bit 18 clear is a 1 MiB section. The output address is desc[31:20] followed by va[19:0], with bits 39:32 zero.
- R6: A direct mapping with bit 18 set is a 16 MiB supersection. The output address is built as follows:
  - bits 39:36 come from desc[8:5]
  - bits 35:32 come from desc[23:20]
  - bits 31:24 come from desc[31:24]
  - bits 23:0 come from va[23:0]
- R7: The second read address is l1desc[31:10], then va[19:12], then two zero bits.
- R8: Second-level bits[1:0] decode as follows:
  - 00 gives a fault.
  - 1x is a small page: desc[31:12] followed by va[11:0].
  - 01 is a large page: desc[31:16] followed by va[15:0].
- R9: Write is granted when the read-only bit of the final descriptor is clear. That bit is bit 15 for sections and supersections, and bit 9 for pages. Execute is granted when the execute-never bit is clear. That bit is bit 4 for sections and supersections, bit 0 for small pages, and bit 15 for large pages.
- R10: A memory response with `mem_rsp_err` set ends the walk with status 2 (access error), and no further read is issued.
- R11: Only one request is in flight at a time. `req_ready` is low from acceptance until the response. `rsp_valid` lasts exactly one cycle. A memory request is held, with a stable address, until `mem_req_ready` is high.
- R12: Status 0 means success. For any non-zero status, `rsp_pa`, `rsp_write` and `rsp_exec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_va | input | 32 | Virtual address to translate |
| cfg_n | input | 3 | Base split control |
| cfg_dis0 | input | 1 | Disable walks through base 0 |
| cfg_dis1 | input | 1 | Disable walks through base 1 |
| cfg_base0 | input | 32 | Table base 0 |
| cfg_base1 | input | 32 | Table base 1 |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read failed |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_status | output | 2 | 0 success, 1 fault, 2 access error |
| rsp_pa | output | 40 | Translated address |
| rsp_write | output | 1 | Write permitted |
| rsp_exec | output | 1 | Execute permitted |

## Verification
The bound checker watches the handshake rules on every cycle:
- the one-cycle response pulse,
- `req_ready` staying low while busy,
- the held memory request,
- the zeroed fields on a failed walk,
- no read after an error,
- the limit of two reads per walk.

Base selection, the exact descriptor addresses, the four mapping layouts and the permission bits depend on data. Only the bench's sweeps over every split value, several address patterns and every descriptor kind can show them. Those sweeps compare each result with values the bench computes by arithmetic.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 40;
    localparam int DESC_W = 32;

    typedef enum logic [1:0] {
        WS_OK     = 2'd0,
        WS_FAULT  = 2'd1,
        WS_MEMERR = 2'd2
    } walk_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1_REQ,
        S_L1_WAIT,
        S_L2_REQ,
        S_L2_WAIT,
        S_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        L1K_INVALID,
        L1K_TABLE,
        L1K_MAP
    } l1_kind_e;

    typedef struct packed {
        logic [PA_W-1:0] pa;
        logic            wr;
        logic            ex;
    } map_t;
endpackage

// File: rtl/sdw_base_sel.sv
module sdw_base_sel
    import sdw_pkg::*;
#(
    parameter int N_W = 3
) (
    input  logic [11:0]       va_hi,
    input  logic [N_W-1:0]    n,
    input  logic              dis0,
    input  logic              dis1,
    input  logic [VA_W-1:0]   base0,
    input  logic [VA_W-1:0]   base1,
    output logic [VA_W-1:0]   l1_addr,
    output logic              disabled
);
    localparam int HI_W = 12;

    logic             use1;
    logic [N_W-1:0]   eff_n;
    logic [VA_W-1:0]  base;
    logic [4:0]       base_sh;
    logic [4:0]       top_sh;
    logic [HI_W-1:0]  idx;

    always_comb begin
        top_sh  = 5'(HI_W) - 5'(n);
        use1    = (n != '0) && ((va_hi >> top_sh) != '0);
        eff_n   = use1 ? '0 : n;
        base    = use1 ? base1 : base0;
        disabled = use1 ? dis1 : dis0;
        base_sh = 5'd14 - 5'(eff_n);
        idx     = va_hi & ({HI_W{1'b1}} >> eff_n);
        l1_addr = (base & ({VA_W{1'b1}} << base_sh))
                | ({{(VA_W-HI_W){1'b0}}, idx} << 2);
    end
endmodule

// File: rtl/sdw_l1_decode.sv
module sdw_l1_decode
    import sdw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [23:0]       va_lo,
    output l1_kind_e          kind,
    output logic [VA_W-1:0]   l2_addr,
    output map_t              map
);
    logic [2:0] unused_bits;
    assign unused_bits = {desc[9], desc[3:2]};

    always_comb begin
        unique case (desc[1:0])
            2'b00:   kind = L1K_INVALID;
            2'b01:   kind = L1K_TABLE;
            default: kind = L1K_MAP;
        endcase
        l2_addr = {desc[31:10], va_lo[19:12], 2'b00};
        if (desc[18]) begin
            map.pa = {desc[8:5], desc[23:20], desc[31:24], va_lo[23:0]};
        end else begin
            map.pa = {8'b0, desc[31:20], va_lo[19:0]};
        end
        map.wr = ~desc[15];
        map.ex = ~desc[4];
    end
endmodule

// File: rtl/sdw_l2_decode.sv
module sdw_l2_decode
    import sdw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [15:0]       va_lo,
    output logic              valid,
    output map_t              map
);
    logic [8:0] unused_bits;
    assign unused_bits = {desc[11:10], desc[8:2]};

    always_comb begin
        valid = desc[1:0] != 2'b00;
        if (desc[1]) begin
            map.pa = {8'b0, desc[31:12], va_lo[11:0]};
            map.ex = ~desc[0];
        end else begin
            map.pa = {8'b0, desc[31:16], va_lo[15:0]};
            map.ex = ~desc[15];
        end
        map.wr = ~desc[9];
    end
endmodule

// File: rtl/sdw_walker.sv
module sdw_walker
    import sdw_pkg::*;
#(
    parameter int N_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    input  logic [N_W-1:0]    cfg_n,
    input  logic              cfg_dis0,
    input  logic              cfg_dis1,
    input  logic [31:0]       cfg_base0,
    input  logic [31:0]       cfg_base1,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [39:0]       rsp_pa,
    output logic              rsp_write,
    output logic              rsp_exec
);
    walk_state_e      state, nxt;
    logic [23:0]      va_q;
    logic [VA_W-1:0]  addr_q;
    walk_status_e     status_q;
    map_t             res_q;

    logic [VA_W-1:0]  l1_addr;
    logic             sel_dis;
    l1_kind_e         l1_kind;
    logic [VA_W-1:0]  l2_addr;
    map_t             l1_map;
    logic             l2_valid;
    map_t             l2_map;
    localparam map_t  MAP_NONE = '0;

    sdw_base_sel #(.N_W(N_W)) i_sel (
        .va_hi    (req_va[31:20]),
        .n        (cfg_n),
        .dis0     (cfg_dis0),
        .dis1     (cfg_dis1),
        .base0    (cfg_base0),
        .base1    (cfg_base1),
        .l1_addr  (l1_addr),
        .disabled (sel_dis)
    );

    sdw_l1_decode i_l1 (
        .desc    (mem_rsp_data),
        .va_lo   (va_q),
        .kind    (l1_kind),
        .l2_addr (l2_addr),
        .map     (l1_map)
    );

    sdw_l2_decode i_l2 (
        .desc  (mem_rsp_data),
        .va_lo (va_q[15:0]),
        .valid (l2_valid),
        .map   (l2_map)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = sel_dis ? S_RESP : S_L1_REQ;
            S_L1_REQ:  if (mem_req_ready) nxt = S_L1_WAIT;
            S_L1_WAIT: if (mem_rsp_valid) begin
                           if (!mem_rsp_err && l1_kind == L1K_TABLE) nxt = S_L2_REQ;
                           else nxt = S_RESP;
                       end
            S_L2_REQ:  if (mem_req_ready) nxt = S_L2_WAIT;
            S_L2_WAIT: if (mem_rsp_valid) nxt = S_RESP;
            S_RESP:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q     <= '0;
            addr_q   <= '0;
            status_q <= WS_OK;
            res_q    <= MAP_NONE;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    va_q     <= req_va[23:0];
                    addr_q   <= l1_addr;
                    status_q <= WS_FAULT;
                    res_q    <= MAP_NONE;
                end
                S_L1_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        status_q <= WS_MEMERR;
                    end else begin
                        unique case (l1_kind)
                            L1K_TABLE: addr_q <= l2_addr;
                            L1K_MAP: begin
                                status_q <= WS_OK;
                                res_q    <= l1_map;
                            end
                            default: status_q <= WS_FAULT;
                        endcase
                    end
                end
                S_L2_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        status_q <= WS_MEMERR;
                    end else if (l2_valid) begin
                        status_q <= WS_OK;
                        res_q    <= l2_map;
                    end else begin
                        status_q <= WS_FAULT;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready     = (state == S_IDLE);
    assign mem_req_valid = (state == S_L1_REQ) || (state == S_L2_REQ);
    assign mem_req_addr  = addr_q;
    assign rsp_valid     = (state == S_RESP);
    assign rsp_status    = status_q;
    assign rsp_pa        = res_q.pa;
    assign rsp_write     = res_q.wr;
    assign rsp_exec      = res_q.ex;
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic        mem_rsp_err,
    input logic        rsp_valid,
    input logic [1:0]  rsp_status,
    input logic [39:0] rsp_pa,
    input logic        rsp_write,
    input logic        rsp_exec
);
    logic       saw_err;
    logic [1:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saw_err <= 1'b0;
            rd_cnt  <= '0;
        end else if (req_valid && req_ready) begin
            saw_err <= 1'b0;
            rd_cnt  <= '0;
        end else begin
            if (mem_rsp_valid && mem_rsp_err) saw_err <= 1'b1;
            if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
        end
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_pa == '0 && !rsp_write && !rsp_exec)); // R12
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_status != 2'd3); // R12
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd2) |-> saw_err); // R10
    AST_NO_READ_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        saw_err |-> !mem_req_valid); // R10
    AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= 2'd2); // R4
endmodule

bind sdw_walker sdw_checker i_sdw_checker (.*);

// File: tb/test_sdw_walker.sv
module test_sdw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [2:0]  cfg_n = '0;
    logic        cfg_dis0 = 1'b0;
    logic        cfg_dis1 = 1'b0;
    logic [31:0] cfg_base0 = 32'h1234_5678;
    logic [31:0] cfg_base1 = 32'hCAFE_B9A4;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [39:0] rsp_pa;
    logic        rsp_write;
    logic        rsp_exec;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sdw_walker i_sdw_walker (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2,
                         input int err, output int st, output longint pa, output int w,
                         output int x, output int nrd, output longint a1, output longint a2);
        int n, effn;
        bit sel1, dis;
        longint base, p14, pva;
        n = int'(cfg_n);
        sel1 = (n != 0) && ((longint'(va) >> (32 - n)) != 0);
        effn = sel1 ? 0 : n;
        base = sel1 ? longint'(cfg_base1) : longint'(cfg_base0);
        dis = sel1 ? cfg_dis1 : cfg_dis0;
        p14 = longint'(1) << (14 - effn);
        pva = longint'(1) << (32 - effn);
        a1 = (base / p14) * p14 + ((longint'(va) % pva) / (1 << 20)) * 4;
        a2 = 0; pa = 0; w = 0; x = 0;
        if (dis) begin st = 1; nrd = 0; return; end
        nrd = 1;
        if (err == 1) begin st = 2; return; end
        case (d1 % 4)
            0: st = 1;
            1: begin
                nrd = 2;
                a2 = (longint'(d1) / 1024) * 1024 + ((longint'(va) / 4096) % 256) * 4;
                if (err == 2) st = 2;
                else if (d2 % 4 == 0) st = 1;
                else begin
                    st = 0;
                    if (d2[1]) begin
                        pa = (longint'(d2) / 4096) * 4096 + longint'(va) % 4096;
                        x = !d2[0];
                    end else begin
                        pa = (longint'(d2) / 65536) * 65536 + longint'(va) % 65536;
                        x = !d2[15];
                    end
                    w = !d2[9];
                end
            end
            default: begin
                st = 0;
                if (d1[18])
                    pa = longint'(va) % (1 << 24) + longint'((d1 >> 24) & 255) * (1 << 24)
                       + longint'((d1 >> 20) & 15) * (longint'(1) << 32)
                       + longint'((d1 >> 5) & 15) * (longint'(1) << 36);
                else
                    pa = (longint'(d1) / (1 << 20)) * (1 << 20) + longint'(va) % (1 << 20);
                w = !d1[15];
                x = !d1[4];
            end
        endcase
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2,
                            input int err, output int st, output longint pa, output int w,
                            output int x, output int nrd, output longint a1, output longint a2,
                            output bit hung);
        req_va = va;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        nrd = 0; a1 = 0; a2 = 0; st = 3; pa = 0; w = 0; x = 0; hung = 1;
        for (int c = 0; c < 40; c++) begin
            if (rsp_valid) begin
                st = int'(rsp_status); pa = longint'(rsp_pa);
                w = int'(rsp_write); x = int'(rsp_exec); hung = 0;
                break;
            end
            if (mem_req_valid) begin
                if (nrd == 0) a1 = longint'(mem_req_addr); else a2 = longint'(mem_req_addr);
                nrd++;
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data = (nrd == 1) ? d1 : d2;
                mem_rsp_err = (err == nrd);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
    endtask

    task automatic walk_and_check(input logic [31:0] va, input logic [31:0] d1,
                                  input logic [31:0] d2, input int err, input string tag);
        int st, w, x, nrd, est, ew, ex, enrd;
        longint pa, a1, a2, epa, ea1, ea2;
        bit hung;
        model(va, d1, d2, err, est, epa, ew, ex, enrd, ea1, ea2);
        run_walk(va, d1, d2, err, st, pa, w, x, nrd, a1, a2, hung);
        chk({tag, " R11 response"}, hung, 0);
        chk({tag, " R4 R12 status"}, st, est);
        chk({tag, " R5 R6 R8 address"}, pa, epa);
        chk({tag, " R9 write"}, w, ew);
        chk({tag, " R9 exec"}, x, ex);
        chk({tag, " R2 R10 reads"}, nrd, enrd);
        if (enrd >= 1 && nrd >= 1) chk({tag, " R1 R3 first addr"}, a1, ea1);
        if (enrd >= 2 && nrd >= 2) chk({tag, " R7 second addr"}, a2, ea2);
    endtask

    function automatic logic [31:0] mk_d1(input int kind, input logic [31:0] r);
        case (kind)
            0: return r & ~32'h3;
            1: return (r & ~32'h4_0003) | 32'h2 | {31'b0, r[7]};
            2: return (r & ~32'h3) | 32'h4_0002 | {31'b0, r[6]};
            default: return (r & ~32'h3) | 32'h1;
        endcase
    endfunction

    function automatic logic [31:0] mk_d2(input int kind, input logic [31:0] r);
        case (kind)
            3: return r | 32'h2;
            4: return (r & ~32'h3) | 32'h1;
            default: return r & ~32'h3;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset ready", req_ready, 1);
        chk("R11 reset rsp_valid", rsp_valid, 0);
        chk("R11 reset mem_req_valid", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4 R5 R6 R7 R8 R9: sweep split value, address pattern and descriptor kind
        for (int n = 0; n < 8; n++) begin
            cfg_n = 3'(n);
            for (int vi = 0; vi < 5; vi++) begin
                logic [31:0] va;
                va = 32'h9E37_79B9 * 32'(vi * 8 + n + 1);
                if (vi == 0) va = va >> 8;
                if (vi == 1) va = va | 32'h8000_0000;
                if (vi == 4) va = 32'h0000_0000 | (32'h1 << (31 - n));
                for (int k = 0; k < 6; k++) begin
                    logic [31:0] r, r2;
                    r  = (va * 32'h0001_0DCD) ^ (32'h5BD1_E995 * 32'(k + 1 + n));
                    r2 = (r * 32'h2545_F491) ^ 32'h7F4A_7C15;
                    cfg_base0 = 32'h1234_5678 ^ (r << 3);
                    cfg_base1 = 32'hCAFE_B9A4 ^ (r2 >> 2);
                    walk_and_check(va, mk_d1(k, r), mk_d2(k, r2), 0, "sweep");
                end
            end
        end

        // R2: disable bits per selected base
        for (int n = 0; n < 8; n++) begin
            cfg_n = 3'(n);
            for (int db = 0; db < 4; db++) begin
                cfg_dis0 = db[0];
                cfg_dis1 = db[1];
                walk_and_check(32'h0003_4567, mk_d1(1, 32'hA5A5_1234), 32'h0, 0, "R2 low");
                walk_and_check(32'hF123_4567, mk_d1(2, 32'h5A5A_8765), 32'h0, 0, "R2 high");
            end
        end
        cfg_dis0 = 1'b0;
        cfg_dis1 = 1'b0;

        // R10: access error on each read
        for (int n = 0; n < 8; n++) begin
            cfg_n = 3'(n);
            walk_and_check(32'h00AB_CDEF, mk_d1(1, 32'h1357_9BDF), 32'h0, 1, "R10 first");
            walk_and_check(32'h00AB_CDEF, mk_d1(3, 32'h1357_9BDF), mk_d2(3, 32'h2468_ACE0), 2, "R10 second");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule